// File: doc/BRIEF.md
# Event Timer with Match Comparator

This block is a register-mapped event timer. It has one free-running up-counter and one comparator channel. Software reaches it over a plain 32-bit bus with an address, a write strobe, write data and registered read data, so read data appears one cycle after the address. The counter advances by one on every clock while the run bit is set. The channel compares the counter against its comparator value. On equality it sets a status flag and drives an interrupt line.

The channel can deliver the interrupt in two ways. In level mode the line stays high until software clears the flag by writing a one. In edge mode each match gives a single-cycle pulse. In periodic mode the comparator moves forward by a stored period after every match, so the channel fires at a fixed rate without software help. The period is loaded through the comparator address while a one-shot value-set bit is armed. A read-only word reports the counter tick period in femtoseconds.

Top module: `evt_tmr`

## Requirements
- R1: Out of reset, these registers read zero: global config, status, counter and channel config. The comparator reads 0xFFFFFFFF and `irq_o` is low.
- R2: Read data is registered. `rdata_o` shows the register selected by `addr_i` one cycle after the address is presented. The map is: 0x004 tick period (constant `PERIOD_FS`), 0x010 global config, 0x020 status, 0x0F0 counter, 0x100 channel config, 0x108 comparator. Any other address reads zero.
- R3: Global config bit 0 (run) makes the counter add one on every clock. While run is clear the counter holds. Global config bit 1 is stored and read back. Other bits read zero.
- R4: A counter write takes effect only while run is clear. A write while running is dropped and counting goes on.
- R5: A match is a cycle with run set and counter equal to comparator. A match with channel config bit 2 (interrupt enable) set sets status bit 0 at the next clock.
- R6: With channel config bit 1 set (level mode), `irq_o` is high whenever status bit 0 and interrupt enable are both set.
- R7: A status write with bit 0 equal to 1 in level mode clears status bit 0. A write with bit 0 equal to 0 changes nothing. In edge mode status writes are ignored.
- R8: With channel config bit 1 clear (edge mode), each enabled match gives exactly one high cycle on `irq_o`, in the cycle after the match. The status bit is still set.
- R9: Channel config bit 3 selects periodic mode. A comparator write made while bit 6 (value-set) and bit 3 are both set stores the reload period and leaves the comparator unchanged. Any comparator write clears bit 6.
- R10: In periodic mode each match adds the reload period to the comparator.
- R11: Channel config keeps bits 1, 2, 3, 6, 8 and 14 and a 5-bit routing field in bits 13:9. All other bits read zero, so writing all ones reads back 0x00007F4E.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; also the counter tick |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register byte address |
| wr_en_i | input | 1 | Write strobe for the current address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the address |
| irq_o | output | 1 | Channel interrupt, level or pulse |

## Verification
Each result has a fixed delay:
- Read data is due one clock after its address.
- The status bit and the level interrupt are due at the clock after the match cycle.
- An edge pulse is high for exactly one cycle after the match.

The bench counts clock edges. It turns the edge indices at which run was set and cleared into the expected counter value, and from those the expected number of periodic matches and the final comparator value. A scoreboard queue holds one expected word per read. The monitor pops it one edge after the read address was driven and compares shortly after that edge. Interrupt levels are sampled on falling edges at computed offsets from the clock that captured the enabling write.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;
  localparam int DW = 32;

  localparam logic [15:0] OFS_TICK = 16'h0004;
  localparam logic [15:0] OFS_GCFG = 16'h0010;
  localparam logic [15:0] OFS_ISTS = 16'h0020;
  localparam logic [15:0] OFS_MCNT = 16'h00F0;
  localparam logic [15:0] OFS_TCFG = 16'h0100;
  localparam logic [15:0] OFS_TCMP = 16'h0108;

  localparam int B_RUN  = 0;
  localparam int B_LEG  = 1;
  localparam int B_LVL  = 1;
  localparam int B_IE   = 2;
  localparam int B_PER  = 3;
  localparam int B_VSET = 6;
  localparam int B_M32  = 8;
  localparam int B_RT   = 9;
  localparam int RT_W   = 5;
  localparam int B_MSG  = 14;

  localparam logic [DW-1:0] TCFG_MASK =
      (DW'(1) << B_LVL) | (DW'(1) << B_IE) | (DW'(1) << B_PER) |
      (DW'(1) << B_VSET) | (DW'(1) << B_M32) | (DW'(1) << B_MSG) |
      (DW'((1 << RT_W) - 1) << B_RT);
endpackage

// File: rtl/evt_tmr_counter.sv
module evt_tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  // load only lands while stopped; running always wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + CNT_W'(1);
    else if (ld_i)  cnt_q <= ld_val_i;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/evt_tmr_chan.sv
module evt_tmr_chan
  import evt_tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cfg_we_i,
  input  logic             cmp_we_i,
  input  logic             sts_we_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    cfg_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             sts_o,
  output logic             irq_o
);
  logic [DW-1:0]    cfg_q;
  logic [CNT_W-1:0] cmp_q, per_q;
  logic             sts_q, pulse_q;
  logic             lvl, ie, per_md, vset, hit, fire;

  assign lvl    = cfg_q[B_LVL];
  assign ie     = cfg_q[B_IE];
  assign per_md = cfg_q[B_PER];
  assign vset   = cfg_q[B_VSET];
  assign hit    = run_i && (cnt_i == cmp_q);
  assign fire   = hit && ie;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= wdata_i & TCFG_MASK;
    else if (cmp_we_i) cfg_q[B_VSET] <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '1;
      per_q <= '0;
    end else if (cmp_we_i) begin
      if (vset && per_md) per_q <= wdata_i[CNT_W-1:0];
      else                cmp_q <= wdata_i[CNT_W-1:0];
    end else if (hit && per_md) begin
      cmp_q <= cmp_q + per_q;
    end
  end

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             sts_q <= 1'b0;
    else if (fire)                           sts_q <= 1'b1;
    else if (sts_we_i && lvl && wdata_i[0])  sts_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= fire && !lvl;
  end

  assign irq_o = lvl ? (sts_q && ie) : pulse_q;
  assign cfg_o = cfg_q;
  assign cmp_o = cmp_q;
  assign sts_o = sts_q;
endmodule

// File: rtl/evt_tmr_bus.sv
module evt_tmr_bus
  import evt_tmr_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          CNT_W     = 32,
  parameter logic [31:0] PERIOD_FS = 32'd10_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [1:0]        gcfg_wd_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DW-1:0]     cfg_i,
  input  logic [CNT_W-1:0]  cmp_i,
  input  logic              sts_i,
  output logic              run_o,
  output logic              cnt_ld_o,
  output logic              cfg_we_o,
  output logic              cmp_we_o,
  output logic              sts_we_o,
  output logic [DW-1:0]     rdata_o
);
  localparam logic [ADDR_W-1:0] A_TICK = ADDR_W'(OFS_TICK);
  localparam logic [ADDR_W-1:0] A_GCFG = ADDR_W'(OFS_GCFG);
  localparam logic [ADDR_W-1:0] A_ISTS = ADDR_W'(OFS_ISTS);
  localparam logic [ADDR_W-1:0] A_MCNT = ADDR_W'(OFS_MCNT);
  localparam logic [ADDR_W-1:0] A_TCFG = ADDR_W'(OFS_TCFG);
  localparam logic [ADDR_W-1:0] A_TCMP = ADDR_W'(OFS_TCMP);

  logic          run_q, leg_q;
  logic [DW-1:0] cnt_x, cmp_x, rd_d, rdata_q;

  generate
    if (CNT_W == DW) begin : g_full
      assign cnt_x = cnt_i;
      assign cmp_x = cmp_i;
    end else begin : g_ext
      assign cnt_x = {{(DW-CNT_W){1'b0}}, cnt_i};
      assign cmp_x = {{(DW-CNT_W){1'b0}}, cmp_i};
    end
  endgenerate

  assign cnt_ld_o = wr_en_i && (addr_i == A_MCNT);
  assign cfg_we_o = wr_en_i && (addr_i == A_TCFG);
  assign cmp_we_o = wr_en_i && (addr_i == A_TCMP);
  assign sts_we_o = wr_en_i && (addr_i == A_ISTS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      leg_q <= 1'b0;
    end else if (wr_en_i && (addr_i == A_GCFG)) begin
      run_q <= gcfg_wd_i[B_RUN];
      leg_q <= gcfg_wd_i[B_LEG];
    end
  end

  always_comb begin
    rd_d = '0;
    case (addr_i)
      A_TICK: rd_d = PERIOD_FS;
      A_GCFG: rd_d = {{(DW-2){1'b0}}, leg_q, run_q};
      A_ISTS: rd_d = {{(DW-1){1'b0}}, sts_i};
      A_MCNT: rd_d = cnt_x;
      A_TCFG: rd_d = cfg_i;
      A_TCMP: rd_d = cmp_x;
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_d;
  end

  assign run_o   = run_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/evt_tmr.sv
module evt_tmr
  import evt_tmr_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          CNT_W     = 32,
  parameter logic [31:0] PERIOD_FS = 32'd10_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  logic             run_q, cnt_ld, cfg_we, cmp_we, sts_we, sts_q;
  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic [DW-1:0]    cfg_q;

  evt_tmr_bus #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PERIOD_FS(PERIOD_FS)
  ) u_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .gcfg_wd_i (wdata_i[1:0]),
    .cnt_i     (cnt_q),
    .cfg_i     (cfg_q),
    .cmp_i     (cmp_q),
    .sts_i     (sts_q),
    .run_o     (run_q),
    .cnt_ld_o  (cnt_ld),
    .cfg_we_o  (cfg_we),
    .cmp_we_o  (cmp_we),
    .sts_we_o  (sts_we),
    .rdata_o   (rdata_o)
  );

  evt_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_q),
    .ld_i     (cnt_ld),
    .ld_val_i (wdata_i[CNT_W-1:0]),
    .cnt_o    (cnt_q)
  );

  evt_tmr_chan #(.CNT_W(CNT_W)) u_chan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_q),
    .cnt_i    (cnt_q),
    .cfg_we_i (cfg_we),
    .cmp_we_i (cmp_we),
    .sts_we_i (sts_we),
    .wdata_i  (wdata_i),
    .cfg_o    (cfg_q),
    .cmp_o    (cmp_q),
    .sts_o    (sts_q),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/evt_tmr_chk.sv
module evt_tmr_chk
  import evt_tmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              wd0_i,
  input logic              irq_o,
  input logic              run_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  cmp_q,
  input logic              lvl_i,
  input logic              ie_i,
  input logic              vset_i,
  input logic              sts_q
);
  logic wr_cnt, wr_cmp, wr_sts, wr_cfg, match;
  assign wr_cnt = wr_en_i && (addr_i == ADDR_W'(OFS_MCNT));
  assign wr_cmp = wr_en_i && (addr_i == ADDR_W'(OFS_TCMP));
  assign wr_sts = wr_en_i && (addr_i == ADDR_W'(OFS_ISTS));
  assign wr_cfg = wr_en_i && (addr_i == ADDR_W'(OFS_TCFG));
  assign match  = run_q && (cnt_q == cmp_q);

  p_run_inc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  p_stop_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !wr_cnt) |=> $stable(cnt_q));

  p_busy_wr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && wr_cnt) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  p_sts_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && ie_i) |=> sts_q);

  p_lvl_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i && irq_o && !wr_cfg && !(wr_sts && wd0_i)) |=> irq_o);

  p_sts_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q && !(wr_sts && wd0_i && lvl_i)) |=> sts_q);

  p_edge_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_i && irq_o) |-> $past(match && ie_i && !lvl_i));

  p_vset_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmp |=> !vset_i);
endmodule

bind evt_tmr evt_tmr_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_en_i (wr_en_i),
  .wd0_i   (wdata_i[0]),
  .irq_o   (irq_o),
  .run_q   (run_q),
  .cnt_q   (cnt_q),
  .cmp_q   (cmp_q),
  .lvl_i   (cfg_q[1]),
  .ie_i    (cfg_q[2]),
  .vset_i  (cfg_q[6]),
  .sts_q   (sts_q)
);

// File: tb/evt_tmr_bench.sv
`timescale 1ns/1ps
module evt_tmr_bench;
  localparam logic [31:0] PFS = 32'd10_000_000;
  localparam logic [11:0] A_TICK = 12'h004, A_GCFG = 12'h010, A_ISTS = 12'h020,
                          A_MCNT = 12'h0F0, A_TCFG = 12'h100, A_TCMP = 12'h108;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  evt_tmr #(.ADDR_W(12), .CNT_W(32), .PERIOD_FS(PFS)) u_evt_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #5 clk_i = ~clk_i;

  int n_cmp = 0, n_bad = 0, cyc = 0, wr_edge = 0, pulses = 0;
  bit rd_v = 1'b0, cnt_en = 1'b0, done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always @(posedge clk_i) cyc++;

  // monitor: compare read data one edge after the address was driven
  always @(posedge clk_i) begin
    if (rd_v) begin
      #1;
      if (exp_q.size() > 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (rdata_o !== e) begin
          n_bad++;
          $display("FAIL %s: got %h exp %h", t, rdata_o, e);
        end
      end
    end
  end

  always @(negedge clk_i) if (cnt_en && irq_o) pulses++;

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_edge = cyc;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk_i);
    addr_i = a; wr_en_i = 1'b0; rd_v = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk_i);
    rd_v = 1'b0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: got %h exp %h", t, act, e);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: got %h exp %h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    int ea, eb, n, k;
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(1);

    // R1 reset state
    chk({31'd0, irq_o}, 32'd0, "R1 irq reset");
    rd(A_GCFG, 32'd0, "R1 gcfg reset");
    rd(A_ISTS, 32'd0, "R1 status reset");
    rd(A_MCNT, 32'd0, "R1 counter reset");
    rd(A_TCFG, 32'd0, "R1 tcfg reset");
    rd(A_TCMP, 32'hFFFF_FFFF, "R1 comparator reset");
    // R2 map
    rd(A_TICK, PFS, "R2 tick period");
    rd(12'h000, 32'd0, "R2 unmapped");
    rd(12'h0F8, 32'd0, "R2 unmapped 0f8");

    // R3 legacy bit, R11 field mask
    wr(A_GCFG, 32'hFFFF_FFFE);
    rd(A_GCFG, 32'h2, "R3 legacy readback");
    wr(A_TCFG, 32'hFFFF_FFFF);
    rd(A_TCFG, 32'h0000_7F4E, "R11 tcfg mask");
    wr(A_TCFG, 32'h0000_2A00);
    rd(A_TCFG, 32'h0000_2A00, "R11 routing field");
    wr(A_TCFG, 32'd0);
    wr(A_GCFG, 32'd0);

    // R4 counter load while stopped, ignored while running; R3 counting
    wr(A_MCNT, 32'd100);
    rd(A_MCNT, 32'd100, "R4 load stopped");
    wr(A_GCFG, 32'd1); ea = wr_edge;
    wait_n(5);
    wr(A_MCNT, 32'd5);
    wr(A_GCFG, 32'd0); eb = wr_edge;
    rd(A_MCNT, 32'd100 + 32'(eb - ea), "R4 busy write dropped");
    wait_n(4);
    rd(A_MCNT, 32'd100 + 32'(eb - ea), "R3 hold while stopped");

    // R5 R6 R7 level mode
    wr(A_MCNT, 32'd300);
    wr(A_TCMP, 32'd303);
    wr(A_TCFG, 32'h6);
    wr(A_GCFG, 32'd1);
    wait_n(3);
    chk({31'd0, irq_o}, 32'd0, "R6 irq before match");
    wait_n(1);
    chk({31'd0, irq_o}, 32'd1, "R6 irq after match");
    rd(A_ISTS, 32'd1, "R5 status set");
    wr(A_ISTS, 32'd0);
    rd(A_ISTS, 32'd1, "R7 write zero no effect");
    chk({31'd0, irq_o}, 32'd1, "R6 irq held");
    wr(A_ISTS, 32'd1);
    chk({31'd0, irq_o}, 32'd0, "R7 clear drops irq");
    rd(A_ISTS, 32'd0, "R7 status cleared");
    wr(A_GCFG, 32'd0);

    // R8 edge mode, R7 ignored write in edge mode
    wr(A_MCNT, 32'd400);
    wr(A_TCMP, 32'd402);
    wr(A_TCFG, 32'h4);
    wr(A_GCFG, 32'd1);
    wait_n(2);
    chk({31'd0, irq_o}, 32'd0, "R8 no pulse yet");
    wait_n(1);
    chk({31'd0, irq_o}, 32'd1, "R8 pulse");
    wait_n(1);
    chk({31'd0, irq_o}, 32'd0, "R8 pulse one cycle");
    rd(A_ISTS, 32'd1, "R8 status set in edge mode");
    wr(A_ISTS, 32'd1);
    rd(A_ISTS, 32'd1, "R7 edge mode write ignored");
    chk({31'd0, irq_o}, 32'd0, "R8 no irq after pulse");
    wr(A_TCFG, 32'h6);
    chk({31'd0, irq_o}, 32'd1, "R6 level shows pending status");
    wr(A_ISTS, 32'd1);
    chk({31'd0, irq_o}, 32'd0, "R7 level clear");
    wr(A_GCFG, 32'd0);
    wr(A_TCFG, 32'd0);

    // R9 R10 periodic
    wr(A_MCNT, 32'd500);
    wr(A_TCFG, 32'h4C);
    wr(A_TCMP, 32'd4);
    rd(A_TCFG, 32'h0C, "R9 value-set self clears");
    rd(A_TCMP, 32'd402, "R9 comparator unchanged by period load");
    wr(A_TCMP, 32'd503);
    rd(A_TCMP, 32'd503, "R9 plain comparator write");
    pulses = 0;
    cnt_en = 1'b1;
    wr(A_GCFG, 32'd1); ea = wr_edge;
    wait_n(20);
    wr(A_GCFG, 32'd0); eb = wr_edge;
    wait_n(2);
    cnt_en = 1'b0;
    n = eb - ea;
    k = 0;
    for (int v = 503; v <= 500 + n - 1; v += 4) k++;
    chk(32'(pulses), 32'(k), "R10 periodic pulse count");
    rd(A_TCMP, 32'd503 + 32'(4 * k), "R10 comparator advanced");
    rd(A_MCNT, 32'd500 + 32'(n), "R3 counter after periodic run");

    wait_n(3);
    finish_run();
  end
endmodule